// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block interprets the byte stream a serial NOR flash slave receives. An SPI shift register hands it one received byte per strobe together with the chip-select level. For each strobe it returns one response byte. The block decodes the opcode and gathers the address, mode and dummy bytes that follow. It keeps the write-enable latch and then moves into a read, page-program or short-response phase. Storage work goes to an attached storage engine as read, program and erase requests.

Serial bit shifting, multi-lane wiring and the memory array sit outside the block. The part identity is set by parameters: a 24-bit ID, a 16-bit extension and a vendor byte taken from the top of the ID. The array size is also a parameter and must be a power of two. Dual and quad I/O reads take a different number of trailing bytes for two vendor bytes, 0xEF and 0x01. A status write is accepted only when writes are enabled. It consumes one byte, discards the value and clears the latch.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After reset, and whenever `sel` is low, the block is idle: `tx_byte` is 0x00, no request or error is raised, and strobes that arrive while `sel` is low are ignored.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one byte that carries the latch in bit 1, with all other bits zero, and then the block goes back to idle.
- R3: Opcode 0x9F streams the ID bytes, most significant first. When `EXT_ID` is nonzero, its upper byte and then its lower byte follow, for 5 bytes in total. After the last byte the block is idle again.
- R4: Opcodes 0x03 and 0x02/0xA2/0x32, and the erase opcodes 0x20/0x52/0xD8, take 3 address bytes, most significant first. Opcodes 0x0B/0x3B/0x6B take those 3 bytes plus 1 dummy byte.
- R5: Opcode 0xBB takes 4 trailing bytes when the vendor byte (`ID_CODE[23:16]`) is 0xEF or 0x01, and 5 otherwise. Opcode 0xEB takes 6 and 8 trailing bytes under the same rule.
- R6: In the read phase, each strobe raises `rd_req` and returns `mem_rdata` for the current `mem_addr`. The address then increments modulo `ARRAY_BYTES`.
- R7: In the program phase, each strobe raises `wr_req`, with `wr_data` equal to the received byte at the current `mem_addr`. The address then increments.
- R8: After the last address byte of an erase opcode, `erase_req` pulses for one cycle with `mem_addr` set to the address, but only when the latch is set. `erase_kind` is 0 for 0x20, 1 for 0x52 and 2 for 0xD8.
- R9: Opcode 0xC7 with the latch set pulses `erase_req` on the next cycle, with `erase_kind` 3. With the latch clear, it pulses `err_pulse` instead.
- R10: Opcode 0x01 with the latch set consumes one byte and clears the latch. With the latch clear it is ignored, and the next byte is decoded as an opcode.
- R11: An unknown opcode pulses `err_pulse` for one cycle and the block stays idle. Opcode 0x00 does nothing and raises no error.
- R12: `tx_byte` is 0x00 after every strobe taken in the idle, collecting or program phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, 1 = selected |
| rx_valid | input | 1 | Strobe: one received byte this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Response byte for the last strobe |
| err_pulse | output | 1 | One-cycle pulse on an unknown opcode or a refused bulk erase |
| rd_req | output | 1 | Storage read strobe (same cycle as the input strobe) |
| wr_req | output | 1 | Storage program strobe (same cycle as the input strobe) |
| wr_data | output | 8 | Byte to program |
| erase_req | output | 1 | One-cycle erase request |
| erase_kind | output | 2 | Erase size: 0 small, 1 medium, 2 sector, 3 whole array |
| mem_addr | output | $clog2(ARRAY_BYTES) | Current storage address |
| mem_rdata | input | 8 | Storage byte at `mem_addr`, combinational |

## Verification
`tx_byte`, `err_pulse` and `erase_req` are registered. They show the result of a strobe in the cycle after the edge that takes it, so the bench reads them 1 ns after that edge. `rd_req`, `wr_req`, `wr_data` and `mem_addr` answer within the strobe cycle itself, so the bench reads them 1 ns after it drives the strobe on the falling edge, before the rising edge consumes it. The byte counts that depend on the vendor byte are checked by driving the same stream into two instances with different IDs. The check looks at the strobe where each instance starts returning read data.

// File: rtl/sfseq_pkg.sv
// Shared types and opcode values for the flash command sequencer.
// Assumes byte-wide transfers; all values here are fixed by the command set.
package sfseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_COLLECT, ST_PROG, ST_READ, ST_STREAM
    } seq_state_t;

    typedef enum logic [1:0] {
        ACT_PROG, ACT_READ, ACT_ERASE, ACT_STATUS
    } post_act_t;

    typedef enum logic [3:0] {
        CK_NOP, CK_WREN, CK_WRDI, CK_RDSR, CK_IDREAD,
        CK_BULK, CK_WRSR, CK_COLLECT, CK_UNKNOWN
    } cmd_kind_t;

    localparam logic [7:0] OPC_NOP        = 8'h00;
    localparam logic [7:0] OPC_STAT_WR    = 8'h01;
    localparam logic [7:0] OPC_PROG_1     = 8'h02;
    localparam logic [7:0] OPC_RD_SLOW    = 8'h03;
    localparam logic [7:0] OPC_WR_DIS     = 8'h04;
    localparam logic [7:0] OPC_STAT_RD    = 8'h05;
    localparam logic [7:0] OPC_WR_EN      = 8'h06;
    localparam logic [7:0] OPC_RD_FAST    = 8'h0B;
    localparam logic [7:0] OPC_ERS_SMALL  = 8'h20;
    localparam logic [7:0] OPC_PROG_4     = 8'h32;
    localparam logic [7:0] OPC_RD_2OUT    = 8'h3B;
    localparam logic [7:0] OPC_ERS_MID    = 8'h52;
    localparam logic [7:0] OPC_RD_4OUT    = 8'h6B;
    localparam logic [7:0] OPC_ID_RD      = 8'h9F;
    localparam logic [7:0] OPC_PROG_2     = 8'hA2;
    localparam logic [7:0] OPC_RD_2IO     = 8'hBB;
    localparam logic [7:0] OPC_ERS_ALL    = 8'hC7;
    localparam logic [7:0] OPC_ERS_SECT   = 8'hD8;
    localparam logic [7:0] OPC_RD_4IO     = 8'hEB;

    localparam logic [1:0] EK_SMALL = 2'd0;
    localparam logic [1:0] EK_MID   = 2'd1;
    localparam logic [1:0] EK_SECT  = 2'd2;
    localparam logic [1:0] EK_ALL   = 2'd3;

endpackage

// File: rtl/sfseq_decode.sv
// Opcode decoder: classifies a byte received in the idle phase and, for
// commands with trailing bytes, gives the trailing byte count, the phase to
// enter afterwards and the erase size. Purely combinational.
// Assumes VENDOR is the top byte of the part ID.
module sfseq_decode
    import sfseq_pkg::*;
#(
    parameter logic [7:0] VENDOR = 8'h00
) (
    input  logic [7:0] opcode,
    output cmd_kind_t  kind,
    output logic [3:0] need,
    output post_act_t  act,
    output logic [1:0] ekind
);
    localparam logic SHORT_IO = (VENDOR == 8'hEF) || (VENDOR == 8'h01);
    localparam logic [3:0] DUAL_IO_BYTES = SHORT_IO ? 4'd4 : 4'd5;
    localparam logic [3:0] QUAD_IO_BYTES = SHORT_IO ? 4'd6 : 4'd8;

    // Map the opcode onto its command class and collection parameters.
    always_comb begin
        kind  = CK_UNKNOWN;
        need  = 4'd0;
        act   = ACT_READ;
        ekind = EK_SMALL;
        unique case (opcode)
            OPC_NOP:     kind = CK_NOP;
            OPC_WR_EN:   kind = CK_WREN;
            OPC_WR_DIS:  kind = CK_WRDI;
            OPC_STAT_RD: kind = CK_RDSR;
            OPC_ID_RD:   kind = CK_IDREAD;
            OPC_ERS_ALL: kind = CK_BULK;
            OPC_STAT_WR: begin kind = CK_WRSR; need = 4'd1; act = ACT_STATUS; end
            OPC_PROG_1, OPC_PROG_2, OPC_PROG_4: begin
                kind = CK_COLLECT; need = 4'd3; act = ACT_PROG;
            end
            OPC_RD_SLOW: begin kind = CK_COLLECT; need = 4'd3; act = ACT_READ; end
            OPC_RD_FAST, OPC_RD_2OUT, OPC_RD_4OUT: begin
                kind = CK_COLLECT; need = 4'd4; act = ACT_READ;
            end
            OPC_RD_2IO: begin kind = CK_COLLECT; need = DUAL_IO_BYTES; act = ACT_READ; end
            OPC_RD_4IO: begin kind = CK_COLLECT; need = QUAD_IO_BYTES; act = ACT_READ; end
            OPC_ERS_SMALL: begin kind = CK_COLLECT; need = 4'd3; act = ACT_ERASE; ekind = EK_SMALL; end
            OPC_ERS_MID:   begin kind = CK_COLLECT; need = 4'd3; act = ACT_ERASE; ekind = EK_MID; end
            OPC_ERS_SECT:  begin kind = CK_COLLECT; need = 4'd3; act = ACT_ERASE; ekind = EK_SECT; end
            default: kind = CK_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/sfseq_resp.sv
// Short response buffer: loaded with up to DEPTH bytes in one cycle, then
// hands out one byte per take, first byte from the lowest lane.
// Assumes take is only raised while a response is loaded.
module sfseq_resp #(
    parameter int DEPTH = 5,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [LW-1:0]      load_len,
    input  logic [DEPTH*8-1:0] load_bytes,
    input  logic               take,
    output logic [7:0]         cur_byte,
    output logic               last
);
    logic [7:0]    slot [DEPTH];
    logic [7:0]    lane [DEPTH];
    logic [LW-1:0] pos;
    logic [LW-1:0] len;

    // Split the flat load vector into byte lanes.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        assign lane[g] = load_bytes[8*g +: 8];
    end

    // Hold the response bytes and the read position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos <= '0;
            len <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= 8'h00;
        end else if (load) begin
            pos <= '0;
            len <= load_len;
            for (int i = 0; i < DEPTH; i++) slot[i] <= lane[i];
        end else if (take) begin
            if (last) begin
                pos <= '0;
                len <= '0;
            end else begin
                pos <= pos + LW'(1);
            end
        end
    end

    assign cur_byte = slot[pos];
    assign last     = (pos + LW'(1)) == len;

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (len != '0) |-> (pos < len)); // R3

endmodule

// File: rtl/sflash_cmd_seq.sv
// Serial NOR flash command sequencer: takes one received byte per strobe,
// decodes commands, collects address bytes, keeps the write-enable latch and
// drives read/program/erase requests to a storage engine.
// Assumes ARRAY_BYTES is a power of two and mem_rdata is combinational on
// mem_addr. Responses appear on tx_byte one cycle after the strobe.
module sflash_cmd_seq
    import sfseq_pkg::*;
#(
    parameter logic [23:0] ID_CODE     = 24'h9A3C57,
    parameter logic [15:0] EXT_ID      = 16'h0000,
    parameter int          ARRAY_BYTES = 1 << 20,
    localparam int         AW          = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    output logic [7:0]    tx_byte,
    output logic          err_pulse,
    output logic          rd_req,
    output logic          wr_req,
    output logic [7:0]    wr_data,
    output logic          erase_req,
    output logic [1:0]    erase_kind,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata
);
    localparam logic [7:0] VENDOR    = ID_CODE[23:16];
    localparam int         RESP_MAX  = 5;
    localparam int         RLW       = $clog2(RESP_MAX + 1);
    localparam logic [RLW-1:0] ID_LEN = (EXT_ID != 16'h0000) ? RLW'(5) : RLW'(3);

    seq_state_t    state;
    post_act_t     act_q;
    logic [3:0]    cnt;
    logic [3:0]    need_q;
    logic [23:0]   abuf;
    logic          wel;
    logic [AW-1:0] cur_addr;

    cmd_kind_t     dec_kind;
    logic [3:0]    dec_need;
    post_act_t     dec_act;
    logic [1:0]    dec_ekind;

    logic          stb;
    logic          last_collect;
    logic [23:0]   asm_addr;
    logic          resp_load;
    logic [RLW-1:0] resp_len;
    logic [RESP_MAX*8-1:0] resp_bytes;
    logic [7:0]    resp_byte;
    logic          resp_last;

    assign stb = sel && rx_valid;

    sfseq_decode #(.VENDOR(VENDOR)) u_decode (
        .opcode (rx_byte),
        .kind   (dec_kind),
        .need   (dec_need),
        .act    (dec_act),
        .ekind  (dec_ekind)
    );

    // Choose what the response buffer receives for status and ID reads.
    always_comb begin
        resp_load = stb && (state == ST_IDLE) &&
                    ((dec_kind == CK_RDSR) || (dec_kind == CK_IDREAD));
        if (dec_kind == CK_RDSR) begin
            resp_len   = RLW'(1);
            resp_bytes = {32'h0, 6'b0, wel, 1'b0};
        end else begin
            resp_len   = ID_LEN;
            resp_bytes = {EXT_ID[7:0], EXT_ID[15:8], ID_CODE[7:0], ID_CODE[15:8], ID_CODE[23:16]};
        end
    end

    sfseq_resp #(.DEPTH(RESP_MAX)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!sel),
        .load       (resp_load),
        .load_len   (resp_len),
        .load_bytes (resp_bytes),
        .take       (stb && (state == ST_STREAM)),
        .cur_byte   (resp_byte),
        .last       (resp_last)
    );

    // Address as it stands once the third collected byte is in.
    assign asm_addr     = (cnt == 4'd2) ? {abuf[15:0], rx_byte} : abuf;
    assign last_collect = stb && (state == ST_COLLECT) && ((cnt + 4'd1) == need_q);

    // Storage strobes follow the input strobe in the same cycle.
    assign rd_req   = stb && (state == ST_READ);
    assign wr_req   = stb && (state == ST_PROG);
    assign wr_data  = rx_byte;
    assign mem_addr = cur_addr;

    // Main sequencer: phase, counters, latch, address and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            act_q      <= ACT_READ;
            cnt        <= 4'd0;
            need_q     <= 4'd0;
            abuf       <= 24'h0;
            wel        <= 1'b0;
            cur_addr   <= '0;
            tx_byte    <= 8'h00;
            err_pulse  <= 1'b0;
            erase_req  <= 1'b0;
            erase_kind <= EK_SMALL;
        end else begin
            err_pulse <= 1'b0;
            erase_req <= 1'b0;
            if (!sel) begin
                state   <= ST_IDLE;
                cnt     <= 4'd0;
                tx_byte <= 8'h00;
            end else if (rx_valid) begin
                tx_byte <= 8'h00;
                unique case (state)
                    ST_IDLE: begin
                        unique case (dec_kind)
                            CK_WREN: wel <= 1'b1;
                            CK_WRDI: wel <= 1'b0;
                            CK_RDSR, CK_IDREAD: state <= ST_STREAM;
                            CK_BULK: begin
                                if (wel) begin
                                    erase_req  <= 1'b1;
                                    erase_kind <= EK_ALL;
                                    cur_addr   <= '0;
                                end else begin
                                    err_pulse <= 1'b1;
                                end
                            end
                            CK_WRSR: begin
                                if (wel) begin
                                    state  <= ST_COLLECT;
                                    cnt    <= 4'd0;
                                    need_q <= dec_need;
                                    act_q  <= dec_act;
                                end
                            end
                            CK_COLLECT: begin
                                state      <= ST_COLLECT;
                                cnt        <= 4'd0;
                                need_q     <= dec_need;
                                act_q      <= dec_act;
                                erase_kind <= dec_ekind;
                            end
                            CK_UNKNOWN: err_pulse <= 1'b1;
                            default: ;
                        endcase
                    end
                    ST_COLLECT: begin
                        if (cnt < 4'd3) abuf <= {abuf[15:0], rx_byte};
                        cnt <= cnt + 4'd1;
                        if (last_collect) begin
                            state    <= ST_IDLE;
                            cur_addr <= AW'(asm_addr);
                            unique case (act_q)
                                ACT_PROG:   state <= ST_PROG;
                                ACT_READ:   state <= ST_READ;
                                ACT_ERASE:  if (wel) erase_req <= 1'b1;
                                ACT_STATUS: wel <= 1'b0;
                                default: ;
                            endcase
                        end
                    end
                    ST_PROG: cur_addr <= cur_addr + AW'(1);
                    ST_READ: begin
                        tx_byte  <= mem_rdata;
                        cur_addr <= cur_addr + AW'(1);
                    end
                    ST_STREAM: begin
                        tx_byte <= resp_byte;
                        if (resp_last) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !sel |=> (state == ST_IDLE)); // R1
    AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) erase_req |-> wel); // R8
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rd_req, wr_req, erase_req})); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_COLLECT) |-> (cnt < need_q)); // R4
    AST_STATUS_WRITE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n) (last_collect && act_q == ACT_STATUS) |=> !wel); // R10
    AST_QUIET_TX: assert property (@(posedge clk) disable iff (!rst_n) (stb && (state == ST_IDLE || state == ST_COLLECT || state == ST_PROG)) |=> (tx_byte == 8'h00)); // R12

endmodule

// File: tb/sflash_cmd_seq_tb.sv
module sflash_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AWA = 16;
    localparam int AWB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;

    logic [7:0] tx_a, tx_b, wd_a, wd_b, rdata_a, rdata_b;
    logic err_a, err_b, rd_a, rd_b, wr_a, wr_b, erq_a, erq_b;
    logic [1:0] ek_a, ek_b;
    logic [AWA-1:0] addr_a;
    logic [AWB-1:0] addr_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Storage models: byte at address = low address byte + 0x11.
    assign rdata_a = addr_a[7:0] + 8'h11;
    assign rdata_b = addr_b + 8'h11;

    sflash_cmd_seq #(.ID_CODE(24'h9A3C57), .EXT_ID(16'h1234), .ARRAY_BYTES(1 << AWA)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_a), .err_pulse(err_a), .rd_req(rd_a), .wr_req(wr_a), .wr_data(wd_a),
        .erase_req(erq_a), .erase_kind(ek_a), .mem_addr(addr_a), .mem_rdata(rdata_a));

    sflash_cmd_seq #(.ID_CODE(24'hEF6A21), .EXT_ID(16'h0000), .ARRAY_BYTES(1 << AWB)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_b), .err_pulse(err_b), .rd_req(rd_b), .wr_req(wr_b), .wr_data(wd_b),
        .erase_req(erq_b), .erase_kind(ek_b), .mem_addr(addr_b), .mem_rdata(rdata_b));

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [7:0] s_tx, s_tx_b;
    logic s_err, s_erq, p_rd, p_wr;
    logic [1:0] s_ek;
    logic [AWA-1:0] s_addr, p_addr;
    logic [AWB-1:0] p_addr_b;
    logic [7:0] p_wd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One strobe: combinational outputs read in the strobe cycle,
    // registered outputs read after the consuming edge.
    task automatic xfer(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        #1;
        p_rd = rd_a; p_wr = wr_a; p_addr = addr_a; p_wd = wd_a; p_addr_b = addr_b;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        s_tx = tx_a; s_tx_b = tx_b; s_err = err_a; s_erq = erq_a; s_ek = ek_a; s_addr = addr_a;
    endtask

    task automatic frame();
        @(negedge clk); sel = 1'b0;
        @(negedge clk); sel = 1'b1;
    endtask

    // Vector: {new_frame, req[3:0], rx[7:0], exp_tx[7:0], exp_err}
    localparam int NV = 24;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 4'd12, 8'h05, 8'h00, 1'b0},  // R12 status opcode, quiet tx
        {1'b0, 4'd2,  8'h00, 8'h00, 1'b0},  // R2 latch clear
        {1'b1, 4'd2,  8'h06, 8'h00, 1'b0},  // R2 set latch
        {1'b1, 4'd2,  8'h05, 8'h00, 1'b0},
        {1'b0, 4'd2,  8'h00, 8'h02, 1'b0},  // R2 latch in bit 1
        {1'b1, 4'd3,  8'h9F, 8'h00, 1'b0},
        {1'b0, 4'd3,  8'h00, 8'h9A, 1'b0},  // R3 ID high
        {1'b0, 4'd3,  8'h00, 8'h3C, 1'b0},
        {1'b0, 4'd3,  8'h00, 8'h57, 1'b0},
        {1'b0, 4'd3,  8'h00, 8'h12, 1'b0},  // R3 extension
        {1'b0, 4'd3,  8'h00, 8'h34, 1'b0},
        {1'b0, 4'd3,  8'h00, 8'h00, 1'b0},  // R3 back to idle
        {1'b1, 4'd4,  8'h03, 8'h00, 1'b0},  // R4 slow read
        {1'b0, 4'd4,  8'h00, 8'h00, 1'b0},
        {1'b0, 4'd4,  8'h01, 8'h00, 1'b0},
        {1'b0, 4'd4,  8'hFE, 8'h00, 1'b0},
        {1'b0, 4'd6,  8'h00, 8'h0F, 1'b0},  // R6 read 0x01FE
        {1'b0, 4'd6,  8'h00, 8'h10, 1'b0},
        {1'b0, 4'd6,  8'h00, 8'h11, 1'b0},
        {1'b1, 4'd11, 8'h77, 8'h00, 1'b1},  // R11 unknown opcode
        {1'b0, 4'd11, 8'h00, 8'h00, 1'b0},  // R11 no-op
        {1'b1, 4'd2,  8'h04, 8'h00, 1'b0},  // R2 clear latch
        {1'b1, 4'd2,  8'h05, 8'h00, 1'b0},
        {1'b0, 4'd2,  8'h00, 8'h00, 1'b0}
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset tx", tx_a, 8'h00);
        chk("R1 reset err", err_a, 1'b0);
        chk("R1 reset erase", erq_a, 1'b0);
        chk("R1 reset rd", rd_a, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) frame();
            xfer(VEC[i][16:9]);
            checks++;
            if (s_tx !== VEC[i][8:1] || s_err !== VEC[i][0]) begin
                errors++;
                $display("FAIL R%0d vector %0d actual tx %0h err %0b expected tx %0h err %0b",
                         VEC[i][20:17], i, s_tx, s_err, VEC[i][8:1], VEC[i][0]);
            end
        end

        // R1 strobe while deselected is ignored
        @(negedge clk); sel = 1'b0; rx_valid = 1'b1; rx_byte = 8'h06;
        #1; chk("R1 deselected rd", rd_a, 1'b0);
        @(negedge clk); rx_valid = 1'b0; sel = 1'b1;
        xfer(8'h05); xfer(8'h00);
        chk("R1 deselected strobe ignored", s_tx, 8'h00);

        // R4 fast read with dummy byte
        frame(); xfer(8'h0B); xfer(8'h00); xfer(8'h00); xfer(8'h40); xfer(8'hFF);
        chk("R4 dummy byte quiet", s_tx, 8'h00);
        xfer(8'h00);
        chk("R4 fast read data", s_tx, 8'h51);

        // R5 dual I/O read: 4 bytes on vendor 0xEF, 5 otherwise
        frame(); xfer(8'hBB); xfer(8'h00); xfer(8'h00); xfer(8'h10); xfer(8'hA5);
        xfer(8'h00);
        chk("R5 dual short vendor data", s_tx_b, 8'h21);
        chk("R5 dual long vendor still collecting", s_tx, 8'h00);
        xfer(8'h00);
        chk("R5 dual long vendor data", s_tx, 8'h21);

        // R5 quad I/O read: 6 vs 8 bytes
        frame(); xfer(8'hEB); xfer(8'h00); xfer(8'h00); xfer(8'h20);
        xfer(8'h00); xfer(8'h00); xfer(8'h00);
        xfer(8'h00);
        chk("R5 quad short vendor data", s_tx_b, 8'h31);
        chk("R5 quad long vendor collecting", s_tx, 8'h00);
        xfer(8'h00);
        xfer(8'h00);
        chk("R5 quad long vendor data", s_tx, 8'h31);

        // R6 address wrap on the small array
        frame(); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'hFF);
        xfer(8'h00);
        chk("R6 read strobe", p_rd, 1'b1);
        chk("R6 read small array top", s_tx_b, 8'h10);
        xfer(8'h00);
        chk("R6 small array wraps", p_addr_b, 8'h00);
        chk("R6 large array continues", p_addr, 16'h0100);

        // R7 page program
        frame(); xfer(8'h02); xfer(8'h00); xfer(8'h12); xfer(8'h34);
        xfer(8'hAA);
        chk("R7 program strobe", p_wr, 1'b1);
        chk("R7 program addr", p_addr, 16'h1234);
        chk("R7 program data", p_wd, 8'hAA);
        chk("R12 program tx", s_tx, 8'h00);
        xfer(8'hBB);
        chk("R7 program addr increments", p_addr, 16'h1235);

        // R8 erase refused without latch, accepted with it
        frame(); xfer(8'h04);
        frame(); xfer(8'h20); xfer(8'h00); xfer(8'h40); xfer(8'h00);
        chk("R8 erase refused", s_erq, 1'b0);
        frame(); xfer(8'h06);
        frame(); xfer(8'h52); xfer(8'h01); xfer(8'h80); xfer(8'h00);
        chk("R8 medium erase req", s_erq, 1'b1);
        chk("R8 medium erase kind", s_ek, 2'd1);
        chk("R8 medium erase addr", s_addr, 16'h8000);
        frame(); xfer(8'hD8); xfer(8'h00); xfer(8'h30); xfer(8'h05);
        chk("R8 sector erase kind", s_ek, 2'd2);
        chk("R8 sector erase addr", s_addr, 16'h3005);

        // R9 bulk erase
        frame(); xfer(8'h04);
        frame(); xfer(8'hC7);
        chk("R9 bulk refused err", s_err, 1'b1);
        chk("R9 bulk refused req", s_erq, 1'b0);
        frame(); xfer(8'h06);
        frame(); xfer(8'hC7);
        chk("R9 bulk req", s_erq, 1'b1);
        chk("R9 bulk kind", s_ek, 2'd3);
        chk("R9 bulk no err", s_err, 1'b0);

        // R10 status write clears latch, ignored without latch
        frame(); xfer(8'h06);
        frame(); xfer(8'h01); xfer(8'h55);
        frame(); xfer(8'h05); xfer(8'h00);
        chk("R10 status write clears latch", s_tx, 8'h00);
        frame(); xfer(8'h01); xfer(8'h9F); xfer(8'h00);
        chk("R10 ignored without latch", s_tx, 8'h9A);

        // R3 three-byte ID on the part without extension
        frame(); xfer(8'h9F); xfer(8'h00); xfer(8'h00); xfer(8'h00);
        chk("R3 short ID last byte", s_tx_b, 8'h21);
        xfer(8'h00);
        chk("R3 short ID ends", s_tx_b, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule